// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block is the command front end of an on-chip flash controller. Software issues bus writes whose low byte is a command code. Program, block erase, erase of every unlocked block and lock-bit program are two-write commands. Read array and clear status take a single write. The sequencer checks that each two-write command is completed correctly. It checks the addressed block against a bank of per-block lock bits, which a global lock-disable input can override. Once a command is accepted, the sequencer starts the operation on a flash array port and waits for the array to report done or fail.

The outcome is kept in two sticky error bits that software reads for a full status check. Both bits set means the command sequence was wrong. The upper bit alone means an erase went wrong. The lower bit alone means a program or lock-bit program went wrong. A ready/busy output is low while the array is working, and command writes made during that time are ignored.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `rdy`=1, `stat_err`=00, `read_array`=1, `arr_start`=0 and `lock_state` equals the LOCK_RST parameter (default 8'h81).
- R2: Only bits [7:0] of a write are decoded. First-write codes are 40h program, 20h block erase, A7h erase-all, 77h lock-bit program, FFh read array and 50h clear status. The upper byte has no effect.
- R3: A command accepted on its second write pulses `arr_start` for exactly one cycle, in the cycle after that write. In the same cycle it presents `arr_op` (0 program, 1 block erase, 2 erase-all, 3 lock program), the block and the data from the second write. `rdy` is low from that cycle until the cycle after `arr_done` is sampled.
- R4: For block erase, erase-all and lock program, a second write whose low byte is neither D0h nor FFh sets both error bits and starts nothing.
- R5: A second write of FFh discards the pending command, sets `read_array` and raises no error. Any other accepted command clears `read_array`.
- R6: An unknown first-write code sets both error bits.
- R7: While `lock_dis`=0, a program to a locked block sets only the lower bit and a block erase of a locked block sets only the upper bit, and neither starts. While `lock_dis`=1, both operations start.
- R8: `arr_fail` together with `arr_done` sets the upper bit for block erase or erase-all, and the lower bit for program or lock program.
- R9: The error bits stay set until a 50h write clears them. While either bit is set, a first write of 40h, 20h, A7h or 77h sets both bits and starts nothing.
- R10: While `rdy`=0, writes are ignored: the error bits, the lock bits and `read_array` are left unchanged.
- R11: A successful lock program sets the block's lock bit. A successful block erase clears it. Erase-all drives `arr_mask` with the unlocked blocks, or with all blocks when `lock_dis`=1, and on success clears the lock bits of those blocks.
- R12: `stat_err` is {upper, lower}: 11 sequence error, 10 erase error, 01 program error, 00 no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | DATA_W | Write data; low byte is the command code |
| wr_blk | input | BLK_W | Block addressed by the write |
| lock_dis | input | 1 | Global lock-disable |
| arr_done | input | 1 | Array operation finished |
| arr_fail | input | 1 | Array operation failed (valid with arr_done) |
| arr_start | output | 1 | One-cycle operation start |
| arr_op | output | 2 | Operation kind |
| arr_blk | output | BLK_W | Target block |
| arr_data | output | DATA_W | Program data |
| arr_mask | output | 2**BLK_W | Blocks to erase |
| rdy | output | 1 | Ready (1) / busy (0) |
| stat_err | output | 2 | Sticky error bits {upper, lower} |
| read_array | output | 1 | Read-array mode flag |
| lock_state | output | 2**BLK_W | Per-block lock bits, 1 = locked |

## Verification
The checker assumes that `arr_done` arrives only while the block is busy and that `lock_dis` does not change between the confirming write and the start pulse. Without the second assumption, the lock-gating property would compare the start against a stale override. The bench changes `lock_dis` only between commands, while the block is idle. It raises `arr_done` for one cycle, and only after it has seen a start pulse. Writes during the busy window are made on purpose, to show that they are ignored.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam logic [7:0] CODE_PROG    = 8'h40;
    localparam logic [7:0] CODE_ERASE   = 8'h20;
    localparam logic [7:0] CODE_ERALL   = 8'hA7;
    localparam logic [7:0] CODE_LOCK    = 8'h77;
    localparam logic [7:0] CODE_READ    = 8'hFF;
    localparam logic [7:0] CODE_CLR     = 8'h50;
    localparam logic [7:0] CODE_CONFIRM = 8'hD0;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT2, ST_BUSY} seq_st_e;
    typedef enum logic [1:0] {OP_PROG = 2'd0, OP_ERASE = 2'd1,
                              OP_ERALL = 2'd2, OP_LOCK = 2'd3} arr_op_e;
    typedef enum logic [2:0] {CMD_PROG, CMD_ERASE, CMD_ERALL, CMD_LOCK,
                              CMD_READ, CMD_CLR, CMD_BAD} cmd_e;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       cmd,
    output logic       is_confirm,
    output logic       is_rdarr
);
    always_comb begin
        is_confirm = (code == CODE_CONFIRM);
        is_rdarr   = (code == CODE_READ);
        case (code)
            CODE_PROG:  cmd = CMD_PROG;
            CODE_ERASE: cmd = CMD_ERASE;
            CODE_ERALL: cmd = CMD_ERALL;
            CODE_LOCK:  cmd = CMD_LOCK;
            CODE_READ:  cmd = CMD_READ;
            CODE_CLR:   cmd = CMD_CLR;
            default:    cmd = CMD_BAD;
        endcase
    end
endmodule

// File: rtl/flash_lock_bank.sv
module flash_lock_bank #(
    parameter int                       BLK_W   = 3,
    parameter logic [(1<<BLK_W)-1:0]    RST_VAL = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic [BLK_W-1:0]         set_idx,
    input  logic [(1<<BLK_W)-1:0]    clr_mask,
    output logic [(1<<BLK_W)-1:0]    lock_o
);
    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] lock_d, lock_q;

    always_comb begin
        lock_d = lock_q & ~clr_mask;
        if (set_en) lock_d[set_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= RST_VAL;
        else        lock_q <= lock_d;
    end

    assign lock_o = lock_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int                    BLK_W    = 3,
    parameter int                    DATA_W   = 16,
    parameter logic [(1<<BLK_W)-1:0] LOCK_RST = 'h81
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [BLK_W-1:0]         wr_blk,
    input  logic                     lock_dis,
    input  logic                     arr_done,
    input  logic                     arr_fail,
    output logic                     arr_start,
    output logic [1:0]               arr_op,
    output logic [BLK_W-1:0]         arr_blk,
    output logic [DATA_W-1:0]        arr_data,
    output logic [(1<<BLK_W)-1:0]    arr_mask,
    output logic                     rdy,
    output logic [1:0]               stat_err,
    output logic                     read_array,
    output logic [(1<<BLK_W)-1:0]    lock_state
);
    localparam int NBLK = 1 << BLK_W;
    localparam logic [NBLK-1:0] ONE_HOT0 = {{(NBLK-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_st_e             st;
        arr_op_e             op;
        logic [BLK_W-1:0]    blk;
        logic [DATA_W-1:0]   data;
        logic [NBLK-1:0]     mask;
        logic                err_hi;
        logic                err_lo;
        logic                rd_arr;
        logic                start;
    } seq_s;

    seq_s q, d;

    cmd_e            cmd;
    logic            is_confirm, is_rdarr;
    logic            lock_set_en;
    logic [NBLK-1:0] lock_clr;
    logic [NBLK-1:0] locks;
    logic            blk_locked;

    flash_cmd_decode dec_i (
        .code       (wr_data[7:0]),
        .cmd        (cmd),
        .is_confirm (is_confirm),
        .is_rdarr   (is_rdarr)
    );

    flash_lock_bank #(.BLK_W(BLK_W), .RST_VAL(LOCK_RST)) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (lock_set_en),
        .set_idx  (q.blk),
        .clr_mask (lock_clr),
        .lock_o   (locks)
    );

    assign blk_locked = locks[wr_blk] && !lock_dis;

    always_comb begin
        d           = q;
        d.start     = 1'b0;
        lock_set_en = 1'b0;
        lock_clr    = '0;
        case (q.st)
            ST_IDLE: if (wr_en) begin
                case (cmd)
                    CMD_PROG, CMD_ERASE, CMD_ERALL, CMD_LOCK: begin
                        d.rd_arr = 1'b0;
                        if (q.err_hi || q.err_lo) begin
                            d.err_hi = 1'b1;
                            d.err_lo = 1'b1;
                        end else begin
                            d.st = ST_WAIT2;
                            case (cmd)
                                CMD_PROG:  d.op = OP_PROG;
                                CMD_ERASE: d.op = OP_ERASE;
                                CMD_ERALL: d.op = OP_ERALL;
                                default:   d.op = OP_LOCK;
                            endcase
                        end
                    end
                    CMD_READ: d.rd_arr = 1'b1;
                    CMD_CLR: begin
                        d.err_hi = 1'b0;
                        d.err_lo = 1'b0;
                        d.rd_arr = 1'b0;
                    end
                    default: begin
                        d.err_hi = 1'b1;
                        d.err_lo = 1'b1;
                        d.rd_arr = 1'b0;
                    end
                endcase
            end
            ST_WAIT2: if (wr_en) begin
                d.st   = ST_IDLE;
                d.blk  = wr_blk;
                d.data = wr_data;
                d.mask = ONE_HOT0 << wr_blk;
                if (q.op == OP_PROG) begin
                    if (blk_locked) d.err_lo = 1'b1;
                    else begin
                        d.st    = ST_BUSY;
                        d.start = 1'b1;
                    end
                end else if (is_rdarr) begin
                    d.rd_arr = 1'b1;
                end else if (!is_confirm) begin
                    d.err_hi = 1'b1;
                    d.err_lo = 1'b1;
                end else if (q.op == OP_ERASE && blk_locked) begin
                    d.err_hi = 1'b1;
                end else begin
                    if (q.op == OP_ERALL) d.mask = lock_dis ? '1 : ~locks;
                    d.st    = ST_BUSY;
                    d.start = 1'b1;
                end
            end
            default: if (arr_done) begin
                d.st = ST_IDLE;
                if (arr_fail) begin
                    if (q.op == OP_ERASE || q.op == OP_ERALL) d.err_hi = 1'b1;
                    else                                      d.err_lo = 1'b1;
                end else begin
                    lock_set_en = (q.op == OP_LOCK);
                    if (q.op == OP_ERASE || q.op == OP_ERALL) lock_clr = q.mask;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_PROG, blk: '0, data: '0, mask: '0,
                   err_hi: 1'b0, err_lo: 1'b0, rd_arr: 1'b1, start: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign arr_start  = q.start;
    assign arr_op     = q.op;
    assign arr_blk    = q.blk;
    assign arr_data   = q.data;
    assign arr_mask   = q.mask;
    assign rdy        = (q.st != ST_BUSY);
    assign stat_err   = {q.err_hi, q.err_lo};
    assign read_array = q.rd_arr;
    assign lock_state = locks;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int BLK_W  = 3,
    parameter int DATA_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [DATA_W-1:0]     wr_data,
    input logic                  lock_dis,
    input logic                  arr_done,
    input logic                  arr_start,
    input logic [1:0]            arr_op,
    input logic [BLK_W-1:0]      arr_blk,
    input logic                  rdy,
    input logic [1:0]            stat_err,
    input logic [(1<<BLK_W)-1:0] lock_state
);
    // R3: a start pulse always coincides with busy and lasts one cycle
    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> !rdy);
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |=> !arr_start);

    // R10: busy persists until done; writes leave status and locks alone
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !arr_done) |=> (!rdy && $stable(lock_state) && $stable(stat_err)));

    // R9: error bits are sticky until a clear-status write
    assert_err_hi_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_err[1] && !(wr_en && wr_data[7:0] == 8'h50)) |=> stat_err[1]);
    assert_err_lo_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_err[0] && !(wr_en && wr_data[7:0] == 8'h50)) |=> stat_err[0]);
    assert_no_start_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> ($past(stat_err) == 2'b00));

    // R7: program and block erase only start on an unlocked block or with override
    assert_lock_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_start && (arr_op == 2'd0 || arr_op == 2'd1)) |-> (lock_dis || !lock_state[arr_blk]));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.BLK_W(BLK_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
    localparam int BLK_W  = 3;
    localparam int DATA_W = 16;
    localparam int NBLK   = 1 << BLK_W;
    localparam int NVEC   = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [BLK_W-1:0]  wr_blk = '0;
    logic              lock_dis = 1'b0;
    logic              arr_done = 1'b0;
    logic              arr_fail = 1'b0;
    logic              arr_start;
    logic [1:0]        arr_op;
    logic [BLK_W-1:0]  arr_blk;
    logic [DATA_W-1:0] arr_data;
    logic [NBLK-1:0]   arr_mask;
    logic              rdy;
    logic [1:0]        stat_err;
    logic              read_array;
    logic [NBLK-1:0]   lock_state;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    flash_cmd_seq #(.BLK_W(BLK_W), .DATA_W(DATA_W), .LOCK_RST(8'h81)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_blk(wr_blk),
        .lock_dis(lock_dis), .arr_done(arr_done), .arr_fail(arr_fail),
        .arr_start(arr_start), .arr_op(arr_op), .arr_blk(arr_blk), .arr_data(arr_data),
        .arr_mask(arr_mask), .rdy(rdy), .stat_err(stat_err), .read_array(read_array),
        .lock_state(lock_state)
    );

    // {first code, second code, block, lock_dis, array fail, expect start, expect err}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h40, 8'hAA, 3'd1, 1'b0, 1'b0, 1'b1, 2'b00},
        {8'h40, 8'h55, 3'd0, 1'b0, 1'b0, 1'b0, 2'b01},
        {8'h40, 8'h55, 3'd0, 1'b1, 1'b0, 1'b1, 2'b00},
        {8'h40, 8'h12, 3'd2, 1'b0, 1'b1, 1'b1, 2'b01},
        {8'h20, 8'hD0, 3'd3, 1'b0, 1'b0, 1'b1, 2'b00},
        {8'h20, 8'hD0, 3'd7, 1'b0, 1'b0, 1'b0, 2'b10},
        {8'h20, 8'hD0, 3'd2, 1'b0, 1'b1, 1'b1, 2'b10},
        {8'h20, 8'h33, 3'd2, 1'b0, 1'b0, 1'b0, 2'b11},
        {8'h20, 8'hFF, 3'd2, 1'b0, 1'b0, 1'b0, 2'b00},
        {8'h77, 8'hD0, 3'd4, 1'b0, 1'b0, 1'b1, 2'b00},
        {8'h77, 8'hD0, 3'd5, 1'b0, 1'b1, 1'b1, 2'b01},
        {8'hA7, 8'hD0, 3'd0, 1'b0, 1'b0, 1'b1, 2'b00},
        {8'hA7, 8'hD0, 3'd0, 1'b0, 1'b1, 1'b1, 2'b10},
        {8'h33, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 2'b11},
        {8'h77, 8'h12, 3'd1, 1'b0, 1'b0, 1'b0, 2'b11}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [DATA_W-1:0] data, input logic [BLK_W-1:0] blk);
        @(negedge clk);
        wr_en = 1'b1; wr_data = data; wr_blk = blk;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; wr_blk = '0;
    endtask

    task automatic finish_op(input logic fail);
        repeat (2) @(negedge clk);
        arr_done = 1'b1; arr_fail = fail;
        @(negedge clk);
        arr_done = 1'b0; arr_fail = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rdy", rdy, 1);
        chk("R1 stat_err", stat_err, 0);
        chk("R1 read_array", read_array, 1);
        chk("R1 arr_start", arr_start, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 lock_state", lock_state, 8'h81);

        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] c1, c2;
            logic       two, started;
            string      tag;
            c1  = VEC[i][23:16];
            c2  = VEC[i][15:8];
            two = (c1 == 8'h40 || c1 == 8'h20 || c1 == 8'hA7 || c1 == 8'h77);
            if (!two)                                   tag = "R6";
            else if (c1 != 8'h40 && c2 == 8'hFF)        tag = "R5";
            else if (c1 != 8'h40 && c2 != 8'hD0)        tag = "R4";
            else if (!VEC[i][2])                        tag = "R7";
            else if (VEC[i][3])                         tag = "R8";
            else                                        tag = "R3";
            lock_dis = VEC[i][4];
            wr(16'h0050, '0);
            wr({8'h00, c1}, '0);
            if (two) wr({8'h00, c2}, VEC[i][7:5]);
            started = arr_start;
            chk($sformatf("%s vec%0d start", tag, i), started, VEC[i][2]);
            if (started) finish_op(VEC[i][3]);
            chk($sformatf("R12 %s vec%0d stat_err", tag, i), stat_err, VEC[i][1:0]);
            lock_dis = 1'b0;
        end
        chk("R11 locks after table", lock_state, 8'h91);

        // R2 and R3: upper byte ignored, start fields, busy window
        wr(16'hAB50, '0);
        wr(16'hC340, 3'd1);
        wr(16'h1234, 3'd1);
        chk("R2 start with upper byte set", arr_start, 1);
        chk("R3 arr_op", arr_op, 0);
        chk("R3 arr_blk", arr_blk, 1);
        chk("R3 arr_data", arr_data, 16'h1234);
        chk("R3 rdy low", rdy, 0);
        // R10: a bad code while busy is ignored
        wr(16'h0033, '0);
        chk("R10 err unchanged while busy", stat_err, 0);
        chk("R10 still busy", rdy, 0);
        finish_op(1'b0);
        chk("R10 ready after done", rdy, 1);

        // R9: sticky errors reject new commands until cleared
        wr(16'h0033, '0);
        wr(16'h0040, 3'd1);
        chk("R9 no start while error", arr_start, 0);
        chk("R9 sequence error held", stat_err, 2'b11);
        wr(16'h0050, '0);
        chk("R9 cleared", stat_err, 0);

        // R5: FFh second write enters read array; clear status leaves it
        wr(16'h0020, '0);
        wr(16'h00FF, 3'd3);
        chk("R5 read_array set", read_array, 1);
        chk("R5 no error", stat_err, 0);
        wr(16'h0050, '0);
        chk("R5 read_array left", read_array, 0);

        // R11: erase-all mask with and without override
        wr(16'h00A7, '0);
        wr(16'h00D0, '0);
        chk("R11 erase-all op", arr_op, 2);
        chk("R11 mask unlocked only", arr_mask, 8'h6E);
        finish_op(1'b0);
        chk("R11 locks kept", lock_state, 8'h91);
        lock_dis = 1'b1;
        wr(16'h00A7, '0);
        wr(16'h00D0, '0);
        chk("R11 mask all with override", arr_mask, 8'hFF);
        finish_op(1'b0);
        lock_dis = 1'b0;
        chk("R11 locks cleared", lock_state, 8'h00);

        // R11 and R7: lock program then overridden erase of the locked block
        wr(16'h0077, '0);
        wr(16'h00D0, 3'd6);
        finish_op(1'b0);
        chk("R11 lock set", lock_state, 8'h40);
        lock_dis = 1'b1;
        wr(16'h0020, '0);
        wr(16'h00D0, 3'd6);
        chk("R7 override start", arr_start, 1);
        finish_op(1'b0);
        lock_dis = 1'b0;
        chk("R11 lock cleared by erase", lock_state, 8'h00);
        chk("R12 no error", stat_err, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule